// File: doc/BRIEF.md
# Microthread Spawn Sequencer

This block turns spawn requests into streams of internal instructions for a decode/rename stage. A request comes from a decoded spawn instruction word or from one of several hardware event lines (mispredict, cache miss, timer and so on). Each request names a routine. The block finds the routine's entry address in a start table, claims a free hardware microcontext and latches the request's 20-bit parameter into that context's read-only parameter register. It then emits the routine's instructions one per accepted cycle, each tagged with its context number and parameter, until an instruction marked as the last one frees the context.

Software words and event lines share one table of 64 routines. Event line i is hard-wired to routine `EVT_BASE + i`, in the same way an interrupt line picks its handler. With every context busy, a request waits in a small in-order queue or is thrown away, depending on a mode input. The start table and the instruction array are filled through a write port before the primary program starts.

Top module: `mthread_spawn_seq`

## Requirements
- R1: A spawn word is read as bits [31:26] opcode (ignored), bits [25:20] routine number, bits [19:0] parameter.
- R2: Routine n starts at the instruction address held in start-table entry n. Instructions are emitted from consecutive addresses up to and including the first one whose end bit is set.
- R3: With `wr_en` high, `wr_sel`=0 writes `wr_data[IADDR_W-1:0]` into start-table entry `wr_addr[5:0]`. `wr_sel`=1 writes `wr_data` into instruction entry `wr_addr`, with `wr_data[INSTR_W]` as the end bit and `wr_data[INSTR_W-1:0]` as the instruction.
- R4: Event line i spawns routine `EVT_BASE`+i (default 60+i) with parameter `evt_param`. Among lines raised together, the lowest index wins and the rest are dropped.
- R5: A software spawn arriving in the same cycle as any event line is dropped.
- R6: A spawn takes the lowest-numbered free context. Every emitted instruction carries that context number and the parameter latched at spawn, and the parameter stays fixed while the context is busy.
- R7: A context is freed by the edge that accepts its end instruction. It can be given to a new spawn at the following edge.
- R8: When more than one context is busy, accepted instructions alternate among them round-robin.
- R9: While `out_valid` is high and `out_ready` is low, all outputs stay unchanged.
- R10: With `cfg_queue_en`=1, a spawn that finds no free context, or finds older requests waiting, enters a 4-entry queue. Queued requests are served oldest first and ahead of new ones.
- R11: With `cfg_queue_en`=0, or with the queue full, a spawn that cannot take a context is discarded.
- R12: After reset no context is busy, `out_valid` is 0 and the queue is empty.
- R13: A request that finds a free context at a clock edge makes its first instruction valid right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_queue_en | input | 1 | 1: queue requests when contexts are busy; 0: drop them |
| sw_valid | input | 1 | Spawn word present this cycle |
| sw_word | input | 32 | Spawn instruction word |
| evt_valid | input | NUM_EVT | Hardware event lines |
| evt_param | input | 20 | Parameter passed with an event spawn |
| wr_en | input | 1 | Table/instruction write strobe |
| wr_sel | input | 1 | 0: start table, 1: instruction array |
| wr_addr | input | IADDR_W | Write address |
| wr_data | input | INSTR_W+1 | Write data (end bit on top for instructions) |
| out_valid | output | 1 | Instruction available |
| out_ready | input | 1 | Downstream accepts the instruction |
| out_instr | output | INSTR_W | Instruction |
| out_end | output | 1 | Last instruction of its routine |
| out_ctx | output | CTX_W | Microcontext number |
| out_param | output | 20 | Parameter register of that context |

## Verification
The hardest situation to reach is a queued request being handed a context in the cycle after another routine's end instruction is taken, while the other context is still streaming. It only happens when several spawns pile up behind busy contexts. The bench gets there by holding `out_ready` low while it issues four or seven spawns, then releasing it. It checks the exact stream position where the queued routine's first instruction appears, and checks how many instructions appear in total when the queue overflows. Randomly sized routines under random backpressure cover the plain streaming path.

// File: rtl/mthread_spawn_seq.sv
module mthread_spawn_seq #(
  parameter int NCTX     = 2,
  parameter int QDEPTH   = 4,
  parameter int NUM_EVT  = 4,
  parameter int EVT_BASE = 60,
  parameter int INSTR_W  = 16,
  parameter int IADDR_W  = 6,
  localparam int CTX_W   = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_queue_en,
  input  logic               sw_valid,
  input  logic [31:0]        sw_word,
  input  logic [NUM_EVT-1:0] evt_valid,
  input  logic [19:0]        evt_param,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [IADDR_W-1:0] wr_addr,
  input  logic [INSTR_W:0]   wr_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [INSTR_W-1:0] out_instr,
  output logic               out_end,
  output logic [CTX_W-1:0]   out_ctx,
  output logic [19:0]        out_param
);
  localparam int IDEPTH = 1 << IADDR_W;
  localparam int QPTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QCNT_W = $clog2(QDEPTH + 1);

  logic [IADDR_W-1:0] start_tbl [64];
  logic [INSTR_W:0]   imem [IDEPTH];
  logic [NCTX-1:0]    busy;
  logic [IADDR_W-1:0] pc  [NCTX];
  logic [19:0]        par [NCTX];
  logic [5:0]         q_num [QDEPTH];
  logic [19:0]        q_par [QDEPTH];
  logic [QPTR_W-1:0]  q_rd, q_wr;
  logic [QCNT_W-1:0]  q_cnt;
  logic [CTX_W-1:0]   rr, sel, hold_ctx, free_idx;
  logic               hold_v, free_ok, inc_v, found;
  logic [5:0]         inc_num;
  logic [19:0]        inc_par;

  wire unused_opcode = ^sw_word[31:26];

  always_comb begin
    inc_v   = sw_valid;
    inc_num = sw_word[25:20];
    inc_par = sw_word[19:0];
    for (int i = NUM_EVT - 1; i >= 0; i--)
      if (evt_valid[i]) begin
        inc_v   = 1'b1;
        inc_num = 6'(EVT_BASE + i);
        inc_par = evt_param;
      end
  end

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = NCTX - 1; i >= 0; i--)
      if (!busy[i]) begin
        free_ok  = 1'b1;
        free_idx = CTX_W'(i);
      end
  end

  wire q_empty = (q_cnt == '0);
  wire q_full  = (q_cnt == QCNT_W'(QDEPTH));
  wire take_q  = free_ok && !q_empty;
  wire alloc   = free_ok && (!q_empty || inc_v);
  wire push    = inc_v && cfg_queue_en && (!free_ok || !q_empty) && (!q_full || take_q);
  wire [5:0]  a_num = take_q ? q_num[q_rd] : inc_num;
  wire [19:0] a_par = take_q ? q_par[q_rd] : inc_par;

  always_comb begin
    sel   = rr;
    found = 1'b0;
    for (int k = 1; k <= NCTX; k++) begin
      int idx;
      idx = (int'(rr) + k) % NCTX;
      if (!found && busy[idx]) begin
        sel   = CTX_W'(idx);
        found = 1'b1;
      end
    end
    if (hold_v) sel = hold_ctx;
  end

  assign out_valid              = busy[sel];
  assign {out_end, out_instr}   = imem[pc[sel]];
  assign out_ctx                = sel;
  assign out_param              = par[sel];
  wire   fire                   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (wr_en && !wr_sel) start_tbl[wr_addr[5:0]] <= wr_data[IADDR_W-1:0];
    if (wr_en && wr_sel)  imem[wr_addr] <= wr_data;
    if (push) begin
      q_num[q_wr] <= inc_num;
      q_par[q_wr] <= inc_par;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= '0;
      rr       <= CTX_W'(NCTX - 1);
      hold_v   <= 1'b0;
      hold_ctx <= '0;
      q_rd     <= '0;
      q_wr     <= '0;
      q_cnt    <= '0;
      for (int i = 0; i < NCTX; i++) begin
        pc[i]  <= '0;
        par[i] <= '0;
      end
    end else begin
      if (fire) begin
        if (out_end) busy[sel] <= 1'b0;
        else         pc[sel]   <= pc[sel] + 1'b1;
        rr <= sel;
      end
      if (alloc) begin
        busy[free_idx] <= 1'b1;
        pc[free_idx]   <= start_tbl[a_num];
        par[free_idx]  <= a_par;
      end
      hold_v   <= out_valid && !out_ready;
      hold_ctx <= sel;
      if (push)   q_wr <= q_wr + 1'b1;
      if (take_q) q_rd <= q_rd + 1'b1;
      q_cnt <= q_cnt + QCNT_W'(push) - QCNT_W'(take_q);
    end
  end

  assert_reset_idle_R12: assert property (@(posedge clk) !rst_n |=> !out_valid && q_empty);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !wr_en |=> out_valid && $stable(out_instr) && $stable(out_ctx)
      && $stable(out_param) && $stable(out_end));
  assert_end_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && out_end |=> !busy[$past(out_ctx)]);
  assert_event_spawn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_valid) && free_ok && q_empty |=> busy[$past(free_idx)] && par[$past(free_idx)] == $past(evt_param));
  assert_queue_bound_R10: assert property (@(posedge clk) disable iff (!rst_n) q_cnt <= QCNT_W'(QDEPTH));
  assert_drop_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_queue_en && q_empty |=> q_empty);
  for (genvar g = 0; g < NCTX; g++) begin : g_ctx_chk
    assert_param_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy[g] |=> $stable(par[g]));
  end
endmodule

// File: tb/mthread_spawn_seq_test.sv
`timescale 1ns/1ps
module mthread_spawn_seq_test;
  logic clk = 0, rst_n = 0, cfg_queue_en = 0, sw_valid = 0, wr_en = 0, wr_sel = 0, out_ready = 1;
  logic [31:0] sw_word = 0;
  logic [3:0]  evt_valid = 0;
  logic [19:0] evt_param = 0;
  logic [5:0]  wr_addr = 0;
  logic [16:0] wr_data = 0;
  logic        out_valid, out_end;
  logic [15:0] out_instr;
  logic [0:0]  out_ctx;
  logic [19:0] out_param;
  int nchk = 0, nerr = 0, lg_n = 0;
  bit done = 0, rnd_en = 0;
  logic [15:0] lg_ins [512];
  logic [19:0] lg_par [512];
  logic        lg_ctx [512];
  logic        lg_end [512];

  mthread_spawn_seq uut (.clk, .rst_n, .cfg_queue_en, .sw_valid, .sw_word, .evt_valid, .evt_param,
    .wr_en, .wr_sel, .wr_addr, .wr_data, .out_valid, .out_ready, .out_instr, .out_end, .out_ctx, .out_param);

  always #10 clk = ~clk;

  always begin
    @(negedge clk); #5;
    if (out_valid && out_ready && lg_n < 512) begin
      lg_ins[lg_n] = out_instr; lg_par[lg_n] = out_param;
      lg_ctx[lg_n] = out_ctx[0]; lg_end[lg_n] = out_end; lg_n++;
    end
  end

  always @(negedge clk) if (rnd_en) out_ready = 1'($urandom % 2);

  function automatic int rlen(int r); return (r % 4) + 1; endfunction
  function automatic int rbase(int r);
    int b = 0;
    if (r < 16) for (int j = 0; j < r; j++) b += rlen(j);
    else begin b = 40; for (int j = 60; j < r; j++) b += rlen(j); end
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic cycles(input int n); repeat (n) @(negedge clk); endtask

  task automatic wr(input bit s, input int a, input int d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_addr = 6'(a); wr_data = 17'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load_rt(input int r);
    wr(0, r, rbase(r));
    for (int k = 0; k < rlen(r); k++)
      wr(1, rbase(r) + k, {(k == rlen(r) - 1) ? 1'b1 : 1'b0, 8'(r), 8'(k)});
  endtask

  task automatic spawn(input int num, input int p, input int opc);
    @(negedge clk); sw_valid = 1; sw_word = {6'(opc), 6'(num), 20'(p)};
    @(negedge clk); sw_valid = 0;
  endtask

  task automatic verify_ctx(input int c, input int skip, input int r, input int p, input string req);
    int got = 0, seen = 0, bad = 0, badv = 0, expv = 0;
    for (int i = 0; i < lg_n; i++) begin
      if (lg_ctx[i] != c[0]) continue;
      if (seen >= skip && got < rlen(r)) begin
        if (lg_ins[i] != {8'(r), 8'(got)} || lg_par[i] != 20'(p) || lg_end[i] != (got == rlen(r) - 1)) begin
          if (!bad) begin badv = lg_ins[i]; expv = {8'(r), 8'(got)}; end
          bad = 1;
        end
        got++;
      end
      seen++;
    end
    if (bad) chk(0, req, badv, expv);
    else     chk(got == rlen(r), req, got, rlen(r));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] si; logic [19:0] sp; logic sc;
    void'($urandom(32'd20240611));
    cycles(3); rst_n = 1;
    cycles(2);
    chk(out_valid == 0, "R12", out_valid, 0);
    for (int r = 0; r < 16; r++) load_rt(r);
    for (int r = 60; r < 64; r++) load_rt(r);
    chk(out_valid == 0, "R12", out_valid, 0);

    // R13 / R6 / R9: spawn under stall
    out_ready = 0;
    spawn(3, 20'h12345, 0);
    chk(out_valid == 1, "R13", out_valid, 1);
    chk(out_ctx == 0, "R6", out_ctx, 0);
    chk(out_param == 20'h12345, "R6", out_param, 20'h12345);
    chk(out_instr == 16'h0300, "R2", out_instr, 16'h0300);
    si = out_instr; sp = out_param; sc = out_ctx[0];
    cycles(3);
    chk(out_valid && out_instr == si && out_param == sp && out_ctx[0] == sc, "R9", out_instr, si);
    lg_n = 0; out_ready = 1; cycles(10);
    verify_ctx(0, 0, 3, 20'h12345, "R2");

    // R1: opcode field ignored
    lg_n = 0; spawn(2, 20'h00abc, 6'h3f); cycles(10);
    verify_ctx(0, 0, 2, 20'h00abc, "R1");

    // R8: two contexts alternate
    out_ready = 0; spawn(1, 20'h111, 0); spawn(3, 20'h333, 0);
    lg_n = 0; out_ready = 1; cycles(12);
    verify_ctx(0, 0, 1, 20'h111, "R6");
    verify_ctx(1, 0, 3, 20'h333, "R6");
    chk(lg_ctx[0] == 0 && lg_ctx[1] == 1 && lg_ctx[2] == 0, "R8", {lg_ctx[0], lg_ctx[1], lg_ctx[2]}, 3'b010);

    // R4 / R5: events beat software; lowest line wins
    lg_n = 0;
    @(negedge clk); evt_valid = 4'b0110; evt_param = 20'h777; sw_valid = 1; sw_word = {6'd0, 6'd3, 20'h5};
    @(negedge clk); evt_valid = 0; sw_valid = 0;
    cycles(10);
    verify_ctx(0, 0, 61, 20'h777, "R4");
    chk(lg_n == 2, "R5", lg_n, 2);

    // R10 / R7: queued spawns run in order after contexts free
    cfg_queue_en = 1; out_ready = 0;
    spawn(1, 20'h1, 0); spawn(2, 20'h2, 0); spawn(5, 20'h5, 0); spawn(6, 20'h6, 0);
    lg_n = 0; out_ready = 1; cycles(30);
    verify_ctx(0, 0, 1, 20'h1, "R10");
    verify_ctx(0, 2, 5, 20'h5, "R10");
    verify_ctx(1, 0, 2, 20'h2, "R10");
    verify_ctx(1, 3, 6, 20'h6, "R10");
    chk(lg_ins[4] == 16'h0500 && lg_ctx[4] == 0, "R7", lg_ins[4], 16'h0500);
    chk(lg_n == 2 + 3 + 2 + 3, "R10", lg_n, 10);

    // R11: drop mode
    cfg_queue_en = 0; out_ready = 0;
    spawn(1, 20'h1, 0); spawn(2, 20'h2, 0); spawn(3, 20'h3, 0);
    lg_n = 0; out_ready = 1; cycles(20);
    chk(lg_n == 5, "R11", lg_n, 5);
    verify_ctx(1, 0, 2, 20'h2, "R11");

    // R11: full queue drops the seventh request
    cfg_queue_en = 1; out_ready = 0;
    for (int r = 0; r < 7; r++) spawn(r, r, 0);
    lg_n = 0; out_ready = 1; cycles(40);
    chk(lg_n == 13, "R11", lg_n, 13);
    begin
      int n6 = 0;
      for (int i = 0; i < lg_n; i++) if (lg_ins[i][15:8] == 8'd6) n6++;
      chk(n6 == 0, "R11", n6, 0);
    end

    // R3: rewrite a start-table entry
    wr(0, 15, rbase(0));
    lg_n = 0; spawn(15, 20'h99, 0); cycles(10);
    verify_ctx(0, 0, 0, 20'h99, "R3");
    wr(0, 15, rbase(15));

    // R2 / R9: random routines under random backpressure
    for (int it = 0; it < 12; it++) begin
      int r, p;
      r = int'($urandom % 16); p = int'($urandom & 32'hfffff);
      lg_n = 0; rnd_en = 1;
      spawn(r, p, int'($urandom % 64));
      cycles(60); rnd_en = 0; out_ready = 1; cycles(5);
      verify_ctx(0, 0, r, p, "R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule